// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block is a small data cache between a processor load/store port and a slower memory. It holds 1 KB as 32 lines of 32 bytes, looked up by a 32-bit byte address, with one valid bit and one tag per line. The processor presents a request with a read/write flag, an address and write data. It holds the request until `wait_o` is low in a cycle. The access completes at the clock edge that ends that cycle.

Stores are write-through and never allocate. A store that hits updates the cached word. Every store, hit or miss, is queued in a four-entry posted write queue. The queue drains to memory in the order it was filled, while the processor keeps running. A load that misses first lets the queue empty, then fetches the whole line as eight word reads, marks the line valid and completes. The memory side is a simple request/acknowledge port, one word per transfer.

Top module: `wt_dcache`

## Requirements
- R1: A byte address splits into tag [31:10], line index [9:5] and word-in-line [4:2]; bits [1:0] are ignored. With the default parameters there are 32 lines of 8 words.
- R2: After reset every line is invalid, so the first read of any line is a miss. With no request pending, `wait_o` and `mem_req_o` are low.
- R3: A read whose line is valid with a matching tag completes in the cycle it is presented, with `wait_o` low and `rdata_o` holding the stored word.
- R4: A read miss issues no memory read until every queued write has been acknowledged. It then reads the line as 8 beats at addresses line_base+0, +4, … +28, in that order, each beat taken on `mem_ack_i`. The read then completes with the requested word.
- R5: A write completes in the cycle it is presented when the queue is not full. It queues the word-aligned address (bits [1:0] cleared) and the data. On a hit it also updates the cached word, so a later read returns the new data.
- R6: A write miss does not fill the line: a later read of that address misses and returns the data from memory.
- R7: The write queue holds 4 entries. With 4 entries pending, a further write is stalled by `wait_o` until an entry drains.
- R8: Queued writes leave on the memory port with `mem_we_o` high, one per entry, in arrival order. Each entry is removed on `mem_ack_i`, and request, address and data stay stable until then.
- R9: A refill replaces the tag of its line, so a read of the line's previous tag then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Processor request pending |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 32 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid when a read completes |
| wait_o | output | 1 | Request not completed this cycle |
| mem_req_o | output | 1 | Memory transfer requested |
| mem_we_o | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr_o | output | 32 | Word-aligned memory address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, taken with mem_ack_i |
| mem_ack_i | input | 1 | Memory transfer completes this cycle |

## Verification
The bench builds the block with its default parameters: 32 lines, 8-word lines and a 4-entry write queue. This configuration is small enough to sweep every line and every word. Each of the 32 indices is filled, checked for beat order and read back word by word. Memory latencies of 0 to 20 cycles bring queue-full stalls and drain-before-refill ordering into reach. Tag conflicts on a shared index and write misses are also exercised.

// File: rtl/wt_dcache_pkg.sv
package wt_dcache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DRAIN  = 2'd1,
    ST_REFILL = 2'd2
  } ctrl_state_e;
endpackage

// File: rtl/wt_dcache_tags.sv
module wt_dcache_tags #(
  parameter int NUM_LINES = 32,
  parameter int IDX_W     = 5,
  parameter int TAG_W     = 22
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic [TAG_W-1:0] rd_tag_i,
  output logic             hit_o,
  input  logic             upd_i,
  input  logic [IDX_W-1:0] upd_idx_i,
  input  logic [TAG_W-1:0] upd_tag_i
);
  logic [NUM_LINES-1:0] valid_w;
  logic [TAG_W-1:0]     tag_w [NUM_LINES];

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic             v_q;
    logic [TAG_W-1:0] t_q;
    logic             sel;
    assign sel = upd_i && (upd_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  v_q <= 1'b0;
      else if (sel) v_q <= 1'b1;
    end

    always_ff @(posedge clk_i) begin
      if (sel) t_q <= upd_tag_i;
    end

    assign valid_w[g] = v_q;
    assign tag_w[g]   = t_q;
  end

  assign hit_o = valid_w[rd_idx_i] && (tag_w[rd_idx_i] == rd_tag_i);

  // R2: valid bits only change through a refill update
  a_r2_valid_set_by_refill_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(valid_w));
endmodule

// File: rtl/wt_dcache_data.sv
module wt_dcache_data #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 256,
  parameter int AW     = 8
) (
  input  logic              clk_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              we_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0] wdata_i
);
  logic [DATA_W-1:0] mem_q [WORDS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[wr_addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[rd_addr_i];
endmodule

// File: rtl/wt_dcache_wbuf.sv
module wt_dcache_wbuf #(
  parameter int DEPTH = 4,
  parameter int W     = 62
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      cnt_q <= cnt_q + CNT_W'(push_i) - CNT_W'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= din_i;
  end

  assign dout_o  = mem_q[rd_ptr_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));

  a_r7_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  a_r8_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/wt_dcache_ctrl.sv
module wt_dcache_ctrl
  import wt_dcache_pkg::*;
#(
  parameter int LINE_W = 27,
  parameter int WOFF_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic              hit_i,
  input  logic              wb_empty_i,
  input  logic              wb_full_i,
  input  logic              mem_ack_i,
  output logic              wait_o,
  output logic              wb_push_o,
  output logic              hit_wr_o,
  output logic              refill_o,
  output logic              refill_we_o,
  output logic              refill_done_o,
  output logic [WOFF_W-1:0] beat_o,
  output logic [LINE_W-1:0] miss_line_o
);
  ctrl_state_e       state_q, state_d;
  logic [WOFF_W-1:0] beat_q;
  logic [LINE_W-1:0] miss_line_q;
  logic              idle, rd_miss, last_beat;

  assign idle      = (state_q == ST_IDLE);
  assign rd_miss   = idle && req_i && !we_i && !hit_i;
  assign last_beat = &beat_q;

  assign wb_push_o     = idle && req_i && we_i && !wb_full_i;
  assign hit_wr_o      = wb_push_o && hit_i;
  assign wait_o        = req_i && !(idle && (we_i ? !wb_full_i : hit_i));
  assign refill_o      = (state_q == ST_REFILL);
  assign refill_we_o   = refill_o && mem_ack_i;
  assign refill_done_o = refill_we_o && last_beat;
  assign beat_o        = beat_q;
  assign miss_line_o   = miss_line_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (rd_miss) state_d = ST_DRAIN;
      ST_DRAIN:  if (wb_empty_i) state_d = ST_REFILL;
      ST_REFILL: if (refill_done_o) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      beat_q      <= '0;
      miss_line_q <= '0;
    end else begin
      state_q <= state_d;
      if (rd_miss) miss_line_q <= line_i;
      if (state_q == ST_DRAIN) beat_q <= '0;
      else if (refill_we_o)    beat_q <= beat_q + 1'b1;
    end
  end

  // R4: no line read while posted writes remain
  a_r4_refill_after_drain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refill_o |-> wb_empty_i);
  // R4: beat only advances on acknowledge
  a_r4_beat_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (refill_o && !mem_ack_i) |=> (refill_o && $stable(beat_q)));
endmodule

// File: rtl/wt_dcache.sv
module wt_dcache #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int NUM_LINES  = 32,
  parameter int WB_DEPTH   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              wait_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ack_i
);
  localparam int OFF_W   = $clog2(LINE_BYTES);
  localparam int BSEL_W  = $clog2(DATA_W / 8);
  localparam int WOFF_W  = OFF_W - BSEL_W;
  localparam int IDX_W   = $clog2(NUM_LINES);
  localparam int TAG_W   = ADDR_W - IDX_W - OFF_W;
  localparam int LINE_W  = ADDR_W - OFF_W;
  localparam int WADDR_W = ADDR_W - BSEL_W;
  localparam int ENT_W   = WADDR_W + DATA_W;
  localparam int DA_W    = IDX_W + WOFF_W;
  localparam int WORDS   = NUM_LINES * (1 << WOFF_W);

  logic [TAG_W-1:0]  cpu_tag;
  logic [IDX_W-1:0]  cpu_idx;
  logic [WOFF_W-1:0] cpu_word;
  logic              hit;
  logic              wb_push, wb_pop, wb_empty, wb_full;
  logic [ENT_W-1:0]  wb_dout;
  logic              hit_wr, refill, refill_we, refill_done;
  logic [WOFF_W-1:0] beat;
  logic [LINE_W-1:0] miss_line;
  logic              dat_we;
  logic [DA_W-1:0]   dat_waddr;
  logic [DATA_W-1:0] dat_wdata;

  assign cpu_tag  = addr_i[ADDR_W-1 -: TAG_W];
  assign cpu_idx  = addr_i[OFF_W +: IDX_W];
  assign cpu_word = addr_i[BSEL_W +: WOFF_W];

  wt_dcache_tags #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) tags_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_idx_i  (cpu_idx),
    .rd_tag_i  (cpu_tag),
    .hit_o     (hit),
    .upd_i     (refill_done),
    .upd_idx_i (miss_line[IDX_W-1:0]),
    .upd_tag_i (miss_line[LINE_W-1:IDX_W])
  );

  assign dat_we    = refill_we || hit_wr;
  assign dat_waddr = refill ? {miss_line[IDX_W-1:0], beat} : {cpu_idx, cpu_word};
  assign dat_wdata = refill ? mem_rdata_i : wdata_i;

  wt_dcache_data #(.DATA_W(DATA_W), .WORDS(WORDS), .AW(DA_W)) data_i (
    .clk_i     (clk_i),
    .rd_addr_i ({cpu_idx, cpu_word}),
    .rdata_o   (rdata_o),
    .we_i      (dat_we),
    .wr_addr_i (dat_waddr),
    .wdata_i   (dat_wdata)
  );

  assign wb_pop = !refill && !wb_empty && mem_ack_i;

  wt_dcache_wbuf #(.DEPTH(WB_DEPTH), .W(ENT_W)) wbuf_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (wb_push),
    .din_i   ({addr_i[ADDR_W-1:BSEL_W], wdata_i}),
    .pop_i   (wb_pop),
    .dout_o  (wb_dout),
    .empty_o (wb_empty),
    .full_o  (wb_full)
  );

  wt_dcache_ctrl #(.LINE_W(LINE_W), .WOFF_W(WOFF_W)) ctrl_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_i         (req_i),
    .we_i          (we_i),
    .line_i        (addr_i[ADDR_W-1:OFF_W]),
    .hit_i         (hit),
    .wb_empty_i    (wb_empty),
    .wb_full_i     (wb_full),
    .mem_ack_i     (mem_ack_i),
    .wait_o        (wait_o),
    .wb_push_o     (wb_push),
    .hit_wr_o      (hit_wr),
    .refill_o      (refill),
    .refill_we_o   (refill_we),
    .refill_done_o (refill_done),
    .beat_o        (beat),
    .miss_line_o   (miss_line)
  );

  // Refill owns the memory port; otherwise the write queue drains.
  assign mem_req_o   = refill || !wb_empty;
  assign mem_we_o    = !refill;
  assign mem_addr_o  = refill ? {miss_line, beat, {BSEL_W{1'b0}}}
                              : {wb_dout[ENT_W-1:DATA_W], {BSEL_W{1'b0}}};
  assign mem_wdata_o = wb_dout[DATA_W-1:0];

  // R8: memory request holds its address until acknowledged
  a_r8_mem_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));
endmodule

// File: tb/wt_dcache_tb_top.sv
`timescale 1ns/1ps
module wt_dcache_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [31:0] addr_i = '0, wdata_i = '0;
  logic [31:0] rdata_o;
  logic        wait_o;
  logic        mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic [31:0] mem_rdata_i;
  logic        mem_ack_i;

  wt_dcache dut_i (.*);

  always #2.5 clk_i = ~clk_i;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [31:0] mem_m [logic [31:0]];
  logic [31:0] exp_wa_q[$], exp_wd_q[$];
  logic [31:0] rd_beats[$];
  int mem_lat = 0, lat_cnt = 0;

  function automatic logic [31:0] init_val(input logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h5a5a_0000;
  endfunction

  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    if (mem_m.exists(a)) return mem_m[a];
    return init_val(a);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Memory responder
  initial begin
    mem_ack_i   = 1'b0;
    mem_rdata_i = '0;
    forever begin
      @(negedge clk_i);
      mem_ack_i = 1'b0;
      if (rst_ni && mem_req_o) begin
        if (lat_cnt >= mem_lat) begin
          lat_cnt   = 0;
          mem_ack_i = 1'b1;
          if (mem_we_o) begin
            if (exp_wa_q.size() == 0) begin
              check(1'b0, "R8 unexpected write", mem_addr_o, 32'h0);
            end else begin
              logic [31:0] ea, ed;
              ea = exp_wa_q.pop_front();
              ed = exp_wd_q.pop_front();
              check(mem_addr_o == ea, "R8/R5 write address order", mem_addr_o, ea);
              check(mem_wdata_o == ed, "R8 write data order", mem_wdata_o, ed);
            end
            mem_m[mem_addr_o] = mem_wdata_o;
          end else begin
            check(exp_wa_q.size() == 0, "R4 refill before drain", 32'(exp_wa_q.size()), 32'd0);
            rd_beats.push_back(mem_addr_o);
            mem_rdata_i = mem_rd(mem_addr_o);
          end
        end else begin
          lat_cnt++;
        end
      end else begin
        lat_cnt = 0;
      end
    end
  end

  task automatic cpu_read(input logic [31:0] a, output logic [31:0] d, output bit hit);
    int cyc = 0;
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    #1;
    hit = !wait_o;
    while (wait_o && cyc < 500) begin
      @(negedge clk_i); #1; cyc++;
    end
    d = rdata_o;
    @(posedge clk_i); #1;
    req_i = 1'b0;
  endtask

  task automatic cpu_write(input logic [31:0] a, input logic [31:0] d, output int stall);
    stall = 0;
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    #1;
    while (wait_o && stall < 500) begin
      @(negedge clk_i); #1; stall++;
    end
    exp_wa_q.push_back({a[31:2], 2'b00});
    exp_wd_q.push_back(d);
    @(posedge clk_i); #1;
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic miss_fill(input logic [31:0] a, input string req);
    logic [31:0] d;
    bit hit;
    bit order_ok;
    rd_beats.delete();
    cpu_read(a, d, hit);
    check(!hit, {req, " miss expected"}, 32'(hit), 32'd0);
    order_ok = (rd_beats.size() == 8);
    for (int k = 0; k < 8 && order_ok; k++)
      if (rd_beats[k] != ({a[31:5], 5'd0} + 32'(4 * k))) order_ok = 1'b0;
    check(order_ok, "R4 beat order", 32'(rd_beats.size()), 32'd8);
    check(d == mem_rd({a[31:2], 2'b00}), "R4 miss data", d, mem_rd({a[31:2], 2'b00}));
  endtask

  initial begin
    logic [31:0] d;
    bit hit;
    int st;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i); #1;
    check(!wait_o, "R2 wait idle after reset", 32'(wait_o), 32'd0);
    check(!mem_req_o, "R2 no memory request after reset", 32'(mem_req_o), 32'd0);

    // R1/R2/R3 sweep of all lines, tag 0
    for (int ln = 0; ln < 32; ln++) begin
      miss_fill(32'(ln * 32 + 8), "R2 cold");
      for (int w = 0; w < 8; w++) begin
        logic [31:0] a;
        a = 32'(ln * 32 + w * 4);
        cpu_read(a + 32'(w % 4), d, hit);   // R1: low two bits ignored
        check(hit, "R3 hit after fill", 32'(hit), 32'd1);
        check(d == init_val(a), "R1 word select", d, init_val(a));
      end
    end

    // R9 conflict with varying latency
    for (int ln = 0; ln < 4; ln++) begin
      mem_lat = ln;
      miss_fill(32'h400 + 32'(ln * 32 + 4), "R9 new tag");
    end
    mem_lat = 0;
    cpu_read(32'h0000_0004, d, hit);
    check(!hit, "R9 old tag evicted", 32'(hit), 32'd0);
    cpu_read(32'h0000_0004, d, hit);
    check(hit && d == init_val(32'h4), "R9 refill back", d, init_val(32'h4));

    // R5 write hit
    cpu_write(32'h0000_00a8, 32'hdead_0005, st);
    check(st == 0, "R5 write no stall", 32'(st), 32'd0);
    cpu_read(32'h0000_00a8, d, hit);
    check(hit && d == 32'hdead_0005, "R5 write hit updates line", d, 32'hdead_0005);
    cpu_write(32'h0000_00af, 32'hbeef_0007, st);  // low bits set, aligned in memory
    cpu_read(32'h0000_00ac, d, hit);
    check(hit && d == 32'hbeef_0007, "R5 unaligned write", d, 32'hbeef_0007);

    // R6 write miss, no allocate
    cpu_write(32'h0000_08a8, 32'hcafe_1234, st);
    cpu_read(32'h0000_08a8, d, hit);
    check(!hit, "R6 write miss not allocated", 32'(hit), 32'd0);
    check(d == 32'hcafe_1234, "R6 data from memory", d, 32'hcafe_1234);
    cpu_read(32'h0000_00a8, d, hit);
    check(!hit, "R9 line replaced by refill", 32'(hit), 32'd0);

    // R7 queue full stall, then R4 drain before refill
    mem_lat = 20;
    for (int k = 0; k < 5; k++) begin
      cpu_write(32'h1000 + 32'(k * 4), 32'h7000_0000 + 32'(k), st);
      if (k < 4) check(st == 0, "R7 no stall below depth", 32'(st), 32'd0);
      else       check(st > 0, "R7 stall when full", 32'(st), 32'd1);
    end
    cpu_write(32'h2004, 32'h1111_2222, st);
    miss_fill(32'h2010, "R4 after writes");
    mem_lat = 0;
    cpu_read(32'h1008, d, hit);
    check(!hit && d == 32'h7000_0002, "R8 drained write visible", d, 32'h7000_0002);
    repeat (10) @(posedge clk_i);
    check(exp_wa_q.size() == 0, "R8 all writes drained", 32'(exp_wa_q.size()), 32'd0);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog expired actual=timeout expected=done");
    finish_run();
  end
endmodule